// File: doc/BRIEF.md
# Floating-Point Exception Mask Unit

This unit sits after a floating-point operation and decides what happens to the exception flags that the operation raised. The flags are compared against a trap-enable mask. A raised flag whose trap is disabled is folded quietly into a sticky accrued field. A raised flag whose trap is enabled either causes a program-interrupt request or is diverted into a per-register poison flag. The diversion happens when the operation was a non-excepting one.

Some trap types are not tied to an IEEE flag. For "unimplemented operation", "sequence error" and "invalid register" the unit raises an interrupt even when no enabled flag is present. Each strobe is evaluated in a single cycle, and every output comes from a register, so the result appears one clock after the strobe.

Top module: `fp_exc_mask_unit`

## Requirements
- R1: While reset is asserted and after it is released, the accrued field and all 64 poison flags are zero, and the irq_valid and done outputs are low.
- R2: On a strobe, the accrued field becomes its old value OR (raised AND NOT enable). Each mask bit has the same meaning in raised, enable, accrued and irq_mask. The accrued field keeps its value in cycles without a strobe.
- R3: On every strobe, irq_mask is loaded with raised AND enable.
- R4: If a strobe has ne_valid high and a non-zero reduced mask (raised AND enable), poison flag number ne_index is set and irq_valid stays low.
- R5: If a strobe has a non-zero reduced mask and is not diverted by R4, irq_valid is high.
- R6: Trap codes 2 (unimplemented operation), 3 (sequence error) and 4 (invalid register) raise irq_valid even when the reduced mask is zero, unless R4 diverts the strobe.
- R7: Trap codes 0 (none), 1 (IEEE exception) and 5 to 7 raise no interrupt when the reduced mask is zero. A strobe with ne_valid high and a zero reduced mask sets no poison flag.
- R8: On every strobe, irq_trap is loaded with the trap code.
- R9: done and irq_valid are one-cycle pulses that appear in the cycle after a strobe. Back-to-back strobes each produce their own result.
- R10: Poison flags are sticky. Once set, a flag is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: evaluate the inputs this cycle |
| raised | input | 5 | Exception flags raised by the operation |
| trap | input | 3 | Trap-type code |
| enable | input | 5 | Trap-enable mask from the FP status register |
| ne_valid | input | 1 | Operation is non-excepting; ne_index is meaningful |
| ne_index | input | 6 | Target FP register of the non-excepting operation |
| accrued | output | 5 | Sticky accrued-exception field |
| irq_valid | output | 1 | Program-interrupt request pulse |
| irq_mask | output | 5 | Reduced (enabled) exception mask of the last strobe |
| irq_trap | output | 3 | Trap code of the last strobe |
| ne_flags | output | 64 | FP poison flags, one per register |
| done | output | 1 | Result pulse, one cycle after each strobe |

## Verification
The bench targets three cases. The first is a forced trap code with a zero reduced mask: a design that demands an enabled flag would drop the interrupt. The second is a non-excepting strobe with a zero reduced mask and a forced trap code: a design that lets ne_valid alone suppress the interrupt would lose it, and one that sets the poison flag anyway would mark register 9. The third is an all-disabled strobe: a design that mixes up the accrue and trap masks would either trap or fail to accumulate. Indices 5 and 63 check that the poison write hits exactly one bit. Idle cycles with active-looking inputs check that nothing moves without a strobe.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_W = 5;
    localparam int TT_W  = 3;

    typedef enum logic [TT_W-1:0] {
        TT_NONE   = 3'd0,
        TT_IEEE   = 3'd1,
        TT_UNIMP  = 3'd2,
        TT_SEQ    = 3'd3,
        TT_BADREG = 3'd4
    } trap_code_e;

    typedef struct packed {
        logic [EXC_W-1:0] accrued;
        logic             issue;
        logic [EXC_W-1:0] mask;
        logic [TT_W-1:0]  trap;
        logic             done;
    } fpx_state_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
(
    input  logic [EXC_W-1:0] raised,
    input  logic [EXC_W-1:0] enable,
    input  logic [TT_W-1:0]  trap,
    input  logic             ne_valid,
    output logic [EXC_W-1:0] reduced,
    output logic [EXC_W-1:0] spill,
    output logic             divert,
    output logic             issue
);
    logic forced;

    always_comb begin
        reduced = raised & enable;
        spill   = raised & ~enable;
        unique case (trap)
            TT_UNIMP, TT_SEQ, TT_BADREG: forced = 1'b1;
            default:                     forced = 1'b0;
        endcase
        divert = ne_valid && (reduced != '0);
        issue  = !divert && ((reduced != '0) || forced);
    end

    always_comb begin
        assert (!(divert && issue)) else $error("p_excl_r4: divert and issue together");
    end
endmodule

// File: rtl/fpx_ne_file.sv
module fpx_ne_file #(
    parameter int NREG = 64,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    output logic [NREG-1:0] flags
);
    for (genvar g = 0; g < NREG; g++) begin : g_bit
        logic bit_d, bit_q;
        always_comb bit_d = bit_q | (set_en && (set_idx == IW'(g)));
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end
        assign flags[g] = bit_q;
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & $past(flags)) == $past(flags));
    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags ^ $past(flags)) <= 1);
endmodule

// File: rtl/fp_exc_mask_unit.sv
module fp_exc_mask_unit
    import fpx_pkg::*;
#(
    parameter int NE_REGS = 64,
    localparam int IDX_W  = $clog2(NE_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [EXC_W-1:0]   raised,
    input  logic [TT_W-1:0]    trap,
    input  logic [EXC_W-1:0]   enable,
    input  logic               ne_valid,
    input  logic [IDX_W-1:0]   ne_index,
    output logic [EXC_W-1:0]   accrued,
    output logic               irq_valid,
    output logic [EXC_W-1:0]   irq_mask,
    output logic [TT_W-1:0]    irq_trap,
    output logic [NE_REGS-1:0] ne_flags,
    output logic               done
);
    fpx_state_t       st_d, st_q;
    logic [EXC_W-1:0] reduced, spill;
    logic             divert, issue;

    fpx_classify u_cls (
        .raised   (raised),
        .enable   (enable),
        .trap     (trap),
        .ne_valid (ne_valid),
        .reduced  (reduced),
        .spill    (spill),
        .divert   (divert),
        .issue    (issue)
    );

    fpx_ne_file #(.NREG(NE_REGS)) u_ne (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (in_valid && divert),
        .set_idx (ne_index),
        .flags   (ne_flags)
    );

    always_comb begin
        st_d       = st_q;
        st_d.issue = 1'b0;
        st_d.done  = 1'b0;
        if (in_valid) begin
            st_d.accrued = st_q.accrued | spill;
            st_d.mask    = reduced;
            st_d.trap    = trap;
            st_d.issue   = issue;
            st_d.done    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accrued   = st_q.accrued;
    assign irq_valid = st_q.issue;
    assign irq_mask  = st_q.mask;
    assign irq_trap  = st_q.trap;
    assign done      = st_q.done;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(accrued));
    p_accrue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((accrued & $past(accrued)) == $past(accrued)));
    p_divert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ne_valid && (raised & enable) != '0) |=> !irq_valid);
    p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ne_valid && trap inside {3'd2, 3'd3, 3'd4}) |=> irq_valid);
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> done);
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
endmodule

// File: tb/fp_exc_mask_unit_tb_top.sv
`timescale 1ns/1ps
module fp_exc_mask_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  raised = '0;
    logic [2:0]  trap = '0;
    logic [4:0]  enable = '0;
    logic        ne_valid = 1'b0;
    logic [5:0]  ne_index = '0;
    logic [4:0]  accrued;
    logic        irq_valid;
    logic [4:0]  irq_mask;
    logic [2:0]  irq_trap;
    logic [63:0] ne_flags;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    logic [4:0]  m_acc;
    logic [63:0] m_ne;

    always #2 clk = ~clk;

    fp_exc_mask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raised(raised),
        .trap(trap), .enable(enable), .ne_valid(ne_valid), .ne_index(ne_index),
        .accrued(accrued), .irq_valid(irq_valid), .irq_mask(irq_mask),
        .irq_trap(irq_trap), .ne_flags(ne_flags), .done(done)
    );

    // fields: raised[20:16] trap[15:13] enable[12:8] ne_valid[7] ne_index[6:1] exp_irq[0]
    localparam int NV = 11;
    localparam logic [20:0] VEC [NV] = '{
        {5'b00011, 3'd1, 5'b00001, 1'b0, 6'd0,  1'b1},
        {5'b00100, 3'd1, 5'b00000, 1'b0, 6'd0,  1'b0},
        {5'b00000, 3'd2, 5'b11111, 1'b0, 6'd0,  1'b1},
        {5'b00000, 3'd3, 5'b11111, 1'b0, 6'd0,  1'b1},
        {5'b00000, 3'd4, 5'b11111, 1'b0, 6'd0,  1'b1},
        {5'b00000, 3'd5, 5'b11111, 1'b0, 6'd0,  1'b0},
        {5'b10000, 3'd1, 5'b10000, 1'b1, 6'd5,  1'b0},
        {5'b00000, 3'd2, 5'b11111, 1'b1, 6'd9,  1'b1},
        {5'b01000, 3'd2, 5'b01000, 1'b1, 6'd63, 1'b0},
        {5'b11111, 3'd0, 5'b00000, 1'b1, 6'd1,  1'b0},
        {5'b00000, 3'd0, 5'b00000, 1'b0, 6'd0,  1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [20:0] v);
        raised   = v[20:16];
        trap     = v[15:13];
        enable   = v[12:8];
        ne_valid = v[7];
        ne_index = v[6:1];
        in_valid = 1'b1;
        m_acc = m_acc | (v[20:16] & ~v[12:8]);
        if (v[7] && (v[20:16] & v[12:8]) != '0) m_ne[v[6:1]] = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual %h expected %h", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_acc = '0;
        m_ne  = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(accrued == 0, "R1 accrued", 64'(accrued), 0);
        check(ne_flags == 0, "R1 ne_flags", ne_flags, 0);
        check(!irq_valid && !done, "R1 pulses", {62'd0, irq_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(accrued == 0 && !done, "R1 after release", 64'(accrued), 0);

        // vector table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check(irq_valid == VEC[i][0], "R5/R6/R7 irq_valid", 64'(irq_valid), 64'(VEC[i][0]));
            check(irq_mask == (VEC[i][20:16] & VEC[i][12:8]), "R3 irq_mask",
                  64'(irq_mask), 64'(VEC[i][20:16] & VEC[i][12:8]));
            check(irq_trap == VEC[i][15:13], "R8 irq_trap", 64'(irq_trap), 64'(VEC[i][15:13]));
            check(accrued == m_acc, "R2 accrued", 64'(accrued), 64'(m_acc));
            check(ne_flags == m_ne, "R4 ne_flags", ne_flags, m_ne);
            check(done == 1'b1, "R9 done", 64'(done), 1);
        end

        // R9: pulses drop after one cycle; R2/R10: idle inputs change nothing
        raised = 5'b00111; enable = 5'b00001; trap = 3'd2; ne_valid = 1'b1; ne_index = 6'd20;
        @(negedge clk);
        check(!irq_valid && !done, "R9 pulse width", {62'd0, irq_valid, done}, 0);
        check(accrued == m_acc, "R2 idle hold", 64'(accrued), 64'(m_acc));
        check(ne_flags == m_ne, "R10 idle flags", ne_flags, m_ne);

        // R9: back-to-back strobes
        apply({5'b00010, 3'd1, 5'b00010, 1'b0, 6'd0, 1'b1});
        @(negedge clk);
        check(irq_valid && irq_mask == 5'b00010, "R9 b2b first", 64'(irq_mask), 64'h2);
        apply({5'b00000, 3'd1, 5'b11111, 1'b0, 6'd0, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        check(!irq_valid && done && irq_mask == 0, "R9 b2b second",
              {57'd0, irq_mask, irq_valid, done}, 64'h1);

        // R10: another set keeps old flags
        apply({5'b00001, 3'd1, 5'b00001, 1'b1, 6'd0, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        check(ne_flags == m_ne && ne_flags[5] && ne_flags[63] && ne_flags[0],
              "R10 sticky", ne_flags, m_ne);

        // R1: reset clears
        rst_n = 1'b0;
        @(negedge clk);
        check(ne_flags == 0 && accrued == 0, "R1 mid reset", ne_flags, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule